// File: doc/BRIEF.md
# Dadda-Scheduled Carry-Save Unsigned Multiplier

This block multiplies two unsigned operands of parameterised widths and returns the full-width product. An array of AND gates forms one partial-product bit for every pairing of a multiplicand bit with a multiplier bit. A carry-save tree of full and half adders then compresses the columns of weighted bits down to two rows. A ripple adder adds the two rows to give the binary product. The tree is laid out by the height-limit schedule 2, 3, 4, 6, 9, ..., which is worked out during elaboration from the operand widths. Each column is reduced only as far as the next limit requires. The tree therefore reaches two rows in the fewest possible levels, while placing as few adder cells as possible at each level.

The operands enter through a valid/ready stream and the product leaves through another. With `OUT_REG` clear, the multiplier is purely combinational: `out_valid` follows `in_valid`, and back-pressure passes straight through, with `in_ready` following `out_ready`. With `OUT_REG` set, a single result register sits at the output. It accepts a new pair whenever it is empty or is being drained in the same cycle, so it sustains one product per cycle. While it is stalled it holds its result and refuses new input. Both operand widths must be at least 2.

Top module: `dadda_mul`

## Requirements
- R1: `out_prod` equals the unsigned product `in_a * in_b`. It is `A_W+B_W` bits wide and has no overflow flag. This holds for every operand pair at the default 4x4 size.
- R2: When both operands are all ones, the exact largest product appears without truncation (225 at 4x4).
- R3: When either operand is zero, the product is zero, whatever the other operand is.
- R4: Unequal operand widths give the correct product for every pair (checked at 5x3).
- R5: With `OUT_REG`=0, in the same cycle `out_valid` equals `in_valid` and `in_ready` equals `out_ready`, and the product reflects the current operands.
- R6: With `OUT_REG`=1, a pair accepted on a rising edge (`in_valid` and `in_ready` both 1) gives `out_valid`=1 and its product right after that edge. A result consumed with no new pair accepted leaves `out_valid`=0 after the edge.
- R7: With `OUT_REG`=1, while `out_valid`=1 and `out_ready`=0:
  - `in_ready` is 0;
  - `out_valid` and `out_prod` hold their values across the edge;
  - an operand pair offered meanwhile is not taken.
- R8: With `OUT_REG`=1, the active-low asynchronous `rst_n` clears `out_valid` at once. While the register is empty, `in_ready` is 1 even with `out_ready`=0.
- R9: With `OUT_REG`=1, `out_ready`=1 keeps `in_ready`=1, so a new pair can be accepted on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional result register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair is offered |
| in_ready | output | 1 | Block can take the offered pair |
| in_a | input | A_W | Unsigned multiplicand |
| in_b | input | B_W | Unsigned multiplier |
| out_valid | output | 1 | Product is present |
| out_ready | input | 1 | Consumer takes the product |
| out_prod | output | A_W+B_W | Unsigned product |

## Verification
On every cycle, the bound checker compares the combinational product with a reference multiplication and checks that the handshake passes straight through. For the registered variant, it checks that an accepted pair lands after one edge, that a stalled result stays put with input refused, and that an empty or draining register offers `in_ready`. Only the bench scenarios can show full value coverage, because the checker sees one operand pair per edge. These scenarios are the exhaustive 4x4 and 5x3 sweeps, the all-ones and zero corners, a long back-to-back stream at 8x8, and a reset that arrives while a result is held.

// File: rtl/dadda_pkg.sv
package dadda_pkg;

  function automatic int min2(int x, int y);
    return (x < y) ? x : y;
  endfunction

  function automatic int max2(int x, int y);
    return (x > y) ? x : y;
  endfunction

  // number of AND terms landing in column c
  function automatic int col_h0(int na, int nb, int c);
    int lo;
    int hi;
    lo = max2(0, c - na + 1);
    hi = min2(nb - 1, c);
    return (hi >= lo) ? (hi - lo + 1) : 0;
  endfunction

  // count of height limits below the tallest column
  function automatic int num_levels(int maxh);
    int d;
    int n;
    d = 2;
    n = 0;
    while (d < maxh) begin
      n++;
      d = (d * 3) / 2;
    end
    return n;
  endfunction

  // height limit that stage s must reach (stage 0 is the first, tallest limit)
  function automatic int level_target(int maxh, int s);
    int d;
    int t;
    t = num_levels(maxh) - 1 - s;
    d = 2;
    for (int i = 0; i < t; i++) d = (d * 3) / 2;
    return d;
  endfunction

  // what: 0 = column height entering the stage, 1 = full adders, 2 = half adders
  function automatic int col_info(int na, int nb, int stage, int col, int what);
    int h [256];
    int maxh, lv, d, cin, ex, nf, nh, res;
    maxh = min2(na, nb);
    lv   = num_levels(maxh);
    res  = 0;
    for (int c = 0; c < 256; c++) h[c] = (c < na + nb) ? col_h0(na, nb, c) : 0;
    for (int s = 0; s <= stage; s++) begin
      d   = (s < lv) ? level_target(maxh, s) : 256;
      cin = 0;
      for (int c = 0; c < na + nb; c++) begin
        ex = h[c] + cin - d;
        nf = 0;
        nh = 0;
        if (ex > 0) begin
          nf = ex / 2;
          nh = ex % 2;
        end
        if (s == stage && c == col) begin
          if (what == 0)      res = h[c];
          else if (what == 1) res = nf;
          else                res = nh;
        end
        h[c] = h[c] - 2 * nf - nh + cin;
        cin  = nf + nh;
      end
    end
    return res;
  endfunction

  // lowest column holding two bits after the last stage
  function automatic int first_pair(int na, int nb);
    int lv;
    lv = num_levels(min2(na, nb));
    for (int c = 0; c < na + nb; c++)
      if (col_info(na, nb, lv, c, 0) == 2) return c;
    return na + nb;
  endfunction

endpackage

// File: rtl/dadda_cell.sv
module dadda_cell #(
  parameter bit FULL = 1'b1
) (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic co
);
  if (FULL) begin : g_full
    assign s  = x ^ y ^ z;
    assign co = (x & y) | (x & z) | (y & z);
  end else begin : g_half
    wire unused_z = z;
    assign s  = x ^ y;
    assign co = x & y;
  end
endmodule

// File: rtl/dadda_pp.sv
module dadda_pp import dadda_pkg::*; #(
  parameter int A_W = 4,
  parameter int B_W = 4
) (
  input  logic [A_W-1:0]                        mcand,
  input  logic [B_W-1:0]                        mplier,
  output wire  [(A_W+B_W)*min2(A_W,B_W)-1:0]    cols
);
  localparam int NC   = A_W + B_W;
  localparam int MAXH = min2(A_W, B_W);

  // slot k of column c holds the term with multiplier bit j = jmin + k
  for (genvar i = 0; i < A_W; i++) begin : g_row
    for (genvar j = 0; j < B_W; j++) begin : g_bit
      localparam int SLOT = j - max2(0, i + j - A_W + 1);
      assign cols[(i + j) * MAXH + SLOT] = mcand[i] & mplier[j];
    end
  end

  for (genvar c = 0; c < NC; c++) begin : g_pad
    for (genvar k = col_h0(A_W, B_W, c); k < MAXH; k++) begin : g_zero
      assign cols[c * MAXH + k] = 1'b0;
    end
  end
endmodule

// File: rtl/dadda_stage.sv
module dadda_stage import dadda_pkg::*; #(
  parameter int A_W   = 4,
  parameter int B_W   = 4,
  parameter int STAGE = 0
) (
  input  logic [(A_W+B_W)*min2(A_W,B_W)-1:0] col_in,
  output wire  [(A_W+B_W)*min2(A_W,B_W)-1:0] col_out
);
  localparam int NC   = A_W + B_W;
  localparam int MAXH = min2(A_W, B_W);

  wire [MAXH-1:0] carries [NC];

  for (genvar c = 0; c < NC; c++) begin : g_col
    localparam int H    = col_info(A_W, B_W, STAGE, c, 0);
    localparam int NF   = col_info(A_W, B_W, STAGE, c, 1);
    localparam int NH   = col_info(A_W, B_W, STAGE, c, 2);
    localparam int BASE = 3 * NF + 2 * NH;
    localparam int NP   = H - BASE;

    logic [MAXH-1:0] here;
    wire  [MAXH-1:0] s_w;
    wire  [MAXH-1:0] c_w;
    wire  [MAXH-1:0] cin_w;

    assign here = col_in[c * MAXH +: MAXH];

    for (genvar f = 0; f < NF; f++) begin : g_fa
      dadda_cell #(.FULL(1'b1)) u_fa (
        .x (here[3 * f]),
        .y (here[3 * f + 1]),
        .z (here[3 * f + 2]),
        .s (s_w[f]),
        .co(c_w[f])
      );
    end

    for (genvar h = 0; h < NH; h++) begin : g_ha
      dadda_cell #(.FULL(1'b0)) u_ha (
        .x (here[3 * NF + 2 * h]),
        .y (here[3 * NF + 2 * h + 1]),
        .z (1'b0),
        .s (s_w[NF + h]),
        .co(c_w[NF + h])
      );
    end

    for (genvar k = NF + NH; k < MAXH; k++) begin : g_idle
      assign s_w[k] = 1'b0;
      assign c_w[k] = 1'b0;
    end

    assign carries[c] = c_w;

    if (c == 0) begin : g_nocin
      assign cin_w = '0;
    end else begin : g_cin
      assign cin_w = carries[c - 1];
    end

    // next column: untouched bits, then sums, then carries from the column below
    assign col_out[c * MAXH +: MAXH] = (here >> BASE)
                                     | (s_w << NP)
                                     | (cin_w << (NP + NF + NH));
  end

  wire unused_top_carry = ^carries[NC - 1];
endmodule

// File: rtl/dadda_cpa.sv
module dadda_cpa #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output wire  [W-1:0] sum
);
  wire [W:0] cy;
  assign cy[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    dadda_cell #(.FULL(1'b1)) u_fa (
      .x (x[i]),
      .y (y[i]),
      .z (cy[i]),
      .s (sum[i]),
      .co(cy[i + 1])
    );
  end

  wire unused_cout = cy[W];
endmodule

// File: rtl/dadda_mul.sv
module dadda_mul import dadda_pkg::*; #(
  parameter int A_W     = 4,
  parameter int B_W     = 4,
  parameter bit OUT_REG = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [A_W-1:0]       in_a,
  input  logic [B_W-1:0]       in_b,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [A_W+B_W-1:0]   out_prod
);
  localparam int NC   = A_W + B_W;
  localparam int MAXH = min2(A_W, B_W);
  localparam int LVL  = num_levels(MAXH);
  localparam int LOW  = first_pair(A_W, B_W);
  localparam int CW   = NC - LOW;

  wire [NC*MAXH-1:0] lvl [LVL + 1];

  dadda_pp #(.A_W(A_W), .B_W(B_W)) u_pp (
    .mcand (in_a),
    .mplier(in_b),
    .cols  (lvl[0])
  );

  for (genvar s = 0; s < LVL; s++) begin : g_stage
    dadda_stage #(.A_W(A_W), .B_W(B_W), .STAGE(s)) u_stage (
      .col_in (lvl[s]),
      .col_out(lvl[s + 1])
    );
  end

  wire [NC-1:0] row0;
  wire [NC-1:0] row1;
  for (genvar c = 0; c < NC; c++) begin : g_rows
    assign row0[c] = lvl[LVL][c * MAXH];
    assign row1[c] = lvl[LVL][c * MAXH + 1];
  end
  wire unused_fin  = ^lvl[LVL];
  wire unused_row1 = ^row1;

  wire [NC-1:0] prod_c;
  if (LOW > 0) begin : g_low
    assign prod_c[LOW-1:0] = row0[LOW-1:0];
  end

  dadda_cpa #(.W(CW)) u_cpa (
    .x  (row0[NC-1:LOW]),
    .y  (row1[NC-1:LOW]),
    .sum(prod_c[NC-1:LOW])
  );

  if (OUT_REG) begin : g_reg
    logic          full_q;
    logic [NC-1:0] prod_q;

    assign in_ready = !full_q || out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full_q <= 1'b0;
        prod_q <= '0;
      end else if (in_valid && in_ready) begin
        full_q <= 1'b1;
        prod_q <= prod_c;
      end else if (out_ready) begin
        full_q <= 1'b0;
      end
    end

    assign out_valid = full_q;
    assign out_prod  = prod_q;
  end else begin : g_comb
    wire unused_ctl = clk ^ rst_n;
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_prod  = prod_c;
  end
endmodule

// File: rtl/dadda_mul_chk.sv
module dadda_mul_chk #(
  parameter int A_W     = 4,
  parameter int B_W     = 4,
  parameter bit OUT_REG = 1'b0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [A_W-1:0]     in_a,
  input logic [B_W-1:0]     in_b,
  input logic               out_valid,
  input logic               out_ready,
  input logic [A_W+B_W-1:0] out_prod
);
  localparam int NC = A_W + B_W;

  logic [NC-1:0] ref_prod;
  assign ref_prod = NC'(in_a) * NC'(in_b);

  if (OUT_REG) begin : g_reg
    AST_REG_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_valid && out_prod == $past(ref_prod))); // R6
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_prod))); // R7
    AST_STALL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready); // R7
    AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready); // R8
    AST_DRAIN_READY: assert property (@(posedge clk) disable iff (!rst_n)
      out_ready |-> in_ready); // R9
  end else begin : g_comb
    AST_COMB_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_prod == ref_prod)); // R1
    AST_PASS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready == out_ready); // R5
    AST_PASS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == in_valid); // R5
  end
endmodule

bind dadda_mul dadda_mul_chk #(.A_W(A_W), .B_W(B_W), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/test_dadda_mul.sv
module test_dadda_mul;
  logic clk = 1'b0;
  always #4 clk = ~clk;
  logic rst_n = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // 4x4 combinational
  logic       a4_valid, a4_ready, a4_ovalid, a4_oready;
  logic [3:0] a4_a, a4_b;
  logic [7:0] a4_prod;
  // 5x3 combinational
  logic       w_valid, w_ready, w_ovalid, w_oready;
  logic [4:0] w_a;
  logic [2:0] w_b;
  logic [7:0] w_prod;
  // 8x8 registered
  logic        r_valid, r_ready, r_ovalid, r_oready;
  logic [7:0]  r_a, r_b;
  logic [15:0] r_prod;

  dadda_mul #(.A_W(4), .B_W(4), .OUT_REG(1'b0)) i_dadda_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(a4_valid), .in_ready(a4_ready),
    .in_a(a4_a), .in_b(a4_b), .out_valid(a4_ovalid), .out_ready(a4_oready),
    .out_prod(a4_prod));

  dadda_mul #(.A_W(5), .B_W(3), .OUT_REG(1'b0)) i_dadda_mul_w (
    .clk(clk), .rst_n(rst_n), .in_valid(w_valid), .in_ready(w_ready),
    .in_a(w_a), .in_b(w_b), .out_valid(w_ovalid), .out_ready(w_oready),
    .out_prod(w_prod));

  dadda_mul #(.A_W(8), .B_W(8), .OUT_REG(1'b1)) i_dadda_mul_r (
    .clk(clk), .rst_n(rst_n), .in_valid(r_valid), .in_ready(r_ready),
    .in_a(r_a), .in_b(r_b), .out_valid(r_ovalid), .out_ready(r_oready),
    .out_prod(r_prod));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  int     pa, pb, exp_p, qa, qb;
  bit     have_prev;
  string  tag;

  initial begin
    a4_valid = 0; a4_oready = 0; a4_a = 0; a4_b = 0;
    w_valid = 0;  w_oready = 0;  w_a = 0;  w_b = 0;
    r_valid = 0;  r_oready = 0;  r_a = 0;  r_b = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(r_ovalid == 1'b0, "R8", r_ovalid, 0);
    check(r_ready == 1'b1, "R8", r_ready, 1);
    rst_n = 1'b1;

    // exhaustive 4x4 sweep, handshake bits toggled from operand bits
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        @(negedge clk);
        a4_a = 4'(a); a4_b = 4'(b);
        a4_valid = a[0]; a4_oready = b[1];
        #1;
        exp_p = a * b;
        if (a == 0 || b == 0)       tag = "R3";
        else if (a == 15 && b == 15) tag = "R2";
        else                         tag = "R1";
        check(a4_prod == 8'(exp_p), tag, a4_prod, exp_p);
        check(a4_ovalid == a4_valid && a4_ready == a4_oready, "R5",
              {a4_ovalid, a4_ready}, {a4_valid, a4_oready});
      end
    end

    // exhaustive 5x3 sweep
    w_valid = 1; w_oready = 1;
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 8; b++) begin
        @(negedge clk);
        w_a = 5'(a); w_b = 3'(b);
        #1;
        exp_p = a * b;
        if (a == 0 || b == 0)       tag = "R3";
        else if (a == 31 && b == 7) tag = "R2";
        else                         tag = "R4";
        check(w_prod == 8'(exp_p), tag, w_prod, exp_p);
      end
    end

    // 8x8 registered: back-to-back stream, corners first
    r_valid = 1; r_oready = 1; have_prev = 0;
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      if (have_prev) begin
        exp_p = pa * pb;
        check(r_ovalid == 1'b1, "R6", r_ovalid, 1);
        check(r_prod == 16'(exp_p), (pa == 255 && pb == 255) ? "R2" : "R6", r_prod, exp_p);
      end
      check(r_ready == 1'b1, "R9", r_ready, 1);
      case (n)
        0: begin pa = 255; pb = 255; end
        1: begin pa = 0;   pb = 200; end
        2: begin pa = 255; pb = 1;   end
        3: begin pa = 128; pb = 128; end
        default: begin pa = int'($urandom % 256); pb = int'($urandom % 256); end
      endcase
      r_a = 8'(pa); r_b = 8'(pb);
      have_prev = 1;
    end
    @(negedge clk);
    exp_p = pa * pb;
    check(r_prod == 16'(exp_p), "R6", r_prod, exp_p);
    r_valid = 0;
    @(negedge clk);
    check(r_ovalid == 1'b0, "R6", r_ovalid, 0);

    // stall: first pair held while a second waits
    pa = 77; pb = 201; qa = 13; qb = 250;
    r_a = 8'(pa); r_b = 8'(pb); r_valid = 1; r_oready = 0;
    @(negedge clk);
    check(r_ovalid == 1'b1 && r_prod == 16'(pa * pb), "R6", r_prod, pa * pb);
    check(r_ready == 1'b0, "R7", r_ready, 0);
    r_a = 8'(qa); r_b = 8'(qb);
    @(negedge clk);
    check(r_ovalid == 1'b1, "R7", r_ovalid, 1);
    check(r_prod == 16'(pa * pb), "R7", r_prod, pa * pb);
    r_oready = 1;
    @(negedge clk);
    check(r_prod == 16'(qa * qb), "R6", r_prod, qa * qb);
    r_valid = 0;
    @(negedge clk);
    check(r_ovalid == 1'b0, "R6", r_ovalid, 0);

    // reset while a result is held
    r_valid = 1; r_oready = 0; r_a = 8'd9; r_b = 8'd9;
    @(negedge clk);
    r_valid = 0;
    check(r_ovalid == 1'b1, "R7", r_ovalid, 1);
    rst_n = 1'b0;
    #1;
    check(r_ovalid == 1'b0, "R8", r_ovalid, 0);
    check(r_ready == 1'b1, "R8", r_ready, 1);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule